// File: doc/BRIEF.md
# Write-Masked Control Register Bank

A bank of 32-bit configuration registers for a storage-interface PHY. It holds seven control words and one read-only status word, and is reached over a plain address/data bus with separate write and read strobes. Each written word carries its own per-bit enable mask in its upper half. Lower bit x of the addressed register takes the written data only when bit x+16 of the same word is 1. Software can therefore change any group of bits with a single store and never needs a read-modify-write.

Selected control fields are decoded straight onto output wires that steer the PHY:

- DLL reference frequency
- drive impedance
- output tap delay enable and select
- power-up
- DLL enable

Two status inputs, calibration done and DLL ready, are gathered into the status word. Software polls that word during the power-up sequence.

Top module: `wmreg_bank`

## Requirements
- R1: A write to a control register updates lower bit x from wdata_i[x] only when wdata_i[x+16] is 1. Every other bit keeps its value, and the register changes on the clock edge that samples we_i.
- R2: The seven control registers are word-aligned at byte offsets 0x00, 0x04, 0x08, 0x0C, 0x10, 0x14 and 0x18, and each one stores independently of the others.
- R3: A read of a control register returns the stored 16 bits in rdata_o[15:0], with rdata_o[31:16] at zero. rdata_o is loaded on the edge that samples re_i and holds until the next read. A read in the same cycle as a write to the same register returns the value before the write.
- R4: The status register at offset 0x20 reads calibration done (cal_done_i) in bit 6 and DLL ready (dll_rdy_i) in bit 5, sampled at the read edge. All other bits read zero.
- R5: Writes are ignored when they target 0x20, an unmapped offset or a misaligned address. Reads of unmapped or misaligned addresses return zero.
- R6: An active-low reset (rst_ni) clears all control registers and rdata_o to zero. This leaves pwr_up_o and dll_en_o at 0: powered down, DLL disabled.
- R7: In the register at 0x18, bit 0 drives pwr_up_o (1 = powered up) and bit 1 drives dll_en_o.
- R8: In the register at 0x18, bits 6:4 drive drv_sel_o. The encoding is 0=50 ohm, 1=33 ohm, 2=66 ohm, 3=100 ohm and 4=40 ohm.
- R9: In the register at 0x00, bits 13:12 drive freq_sel_o. The encoding is 0=200 MHz, 1=50 MHz, 2=100 MHz and 3=150 MHz.
- R10: In the register at 0x00, bit 11 drives tap_en_o and bits 10:7 drive tap_sel_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 6 | Byte address |
| wdata_i | input | 32 | Write word: mask in [31:16], data in [15:0] |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Registered read data |
| cal_done_i | input | 1 | Calibration done status |
| dll_rdy_i | input | 1 | DLL ready status |
| freq_sel_o | output | 2 | DLL frequency select |
| drv_sel_o | output | 3 | Drive impedance select |
| tap_en_o | output | 1 | Output tap delay enable |
| tap_sel_o | output | 4 | Output tap delay select |
| pwr_up_o | output | 1 | PHY power-up control |
| dll_en_o | output | 1 | DLL enable |

## Verification
The assertions assume a few things about the inputs:

- The bus carries at most one write and one read per cycle.
- addr_i and wdata_i are settled at the sampling edge.
- The status inputs are synchronous to clk_i.

The stimulus respects these assumptions. It changes the bus and the status pins only at the falling edge and holds each strobe for exactly one cycle. The status pins are changed only between reads, never during one.

// File: rtl/wmreg_pkg.sv
package wmreg_pkg;
  localparam int DATA_W     = 32;
  localparam int HALF_W     = DATA_W / 2;
  localparam int ADDR_W     = 6;
  localparam int NUM_CTRL   = 7;
  localparam int STAT_OFS   = 'h20;

  // register indices whose fields leave the bank
  localparam int CFG_IDX    = 0;
  localparam int PWR_IDX    = 6;

  localparam int FREQ_LSB   = 12;
  localparam int FREQ_W     = 2;
  localparam int TAPEN_BIT  = 11;
  localparam int TAPSEL_LSB = 7;
  localparam int TAPSEL_W   = 4;
  localparam int PWR_BIT    = 0;
  localparam int DLLEN_BIT  = 1;
  localparam int DRV_LSB    = 4;
  localparam int DRV_W      = 3;

  localparam int CAL_BIT    = 6;
  localparam int RDY_BIT    = 5;
endpackage

// File: rtl/wmreg_decode.sv
module wmreg_decode #(
  parameter int ADDR_W   = 6,
  parameter int NUM_CTRL = 7,
  parameter int STAT_OFS = 'h20
) (
  input  logic [ADDR_W-1:0]   addr_i,
  output logic [NUM_CTRL-1:0] ctrl_sel_o,
  output logic                stat_sel_o
);
  localparam int IDX_W = ADDR_W - 2;

  logic             aligned;
  logic [IDX_W-1:0] word_idx;

  assign aligned  = (addr_i[1:0] == 2'b00);
  assign word_idx = addr_i[ADDR_W-1:2];

  for (genvar i = 0; i < NUM_CTRL; i++) begin : g_sel
    assign ctrl_sel_o[i] = aligned && (word_idx == IDX_W'(i));
  end

  assign stat_sel_o = (addr_i == ADDR_W'(STAT_OFS));
endmodule

// File: rtl/wmreg_cell.sv
module wmreg_cell #(
  parameter int HALF_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [2*HALF_W-1:0] wdata_i,
  output logic [HALF_W-1:0]   q_o
);
  logic [HALF_W-1:0] mask;
  logic [HALF_W-1:0] data;

  assign mask = wdata_i[2*HALF_W-1:HALF_W];
  assign data = wdata_i[HALF_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_o <= '0;
    else if (wr_en_i) q_o <= (q_o & ~mask) | (data & mask);
  end
endmodule

// File: rtl/wmreg_rdmux.sv
module wmreg_rdmux #(
  parameter int DATA_W   = 32,
  parameter int HALF_W   = 16,
  parameter int NUM_CTRL = 7,
  parameter int CAL_BIT  = 6,
  parameter int RDY_BIT  = 5
) (
  input  logic [NUM_CTRL-1:0][HALF_W-1:0] ctrl_q_i,
  input  logic [NUM_CTRL-1:0]             ctrl_sel_i,
  input  logic                            stat_sel_i,
  input  logic                            cal_done_i,
  input  logic                            dll_rdy_i,
  output logic [DATA_W-1:0]               rd_word_o
);
  always_comb begin
    rd_word_o = '0;
    // select lines are one-hot or zero, so an OR tree suffices
    for (int i = 0; i < NUM_CTRL; i++) begin
      if (ctrl_sel_i[i]) rd_word_o[HALF_W-1:0] = rd_word_o[HALF_W-1:0] | ctrl_q_i[i];
    end
    if (stat_sel_i) begin
      rd_word_o[CAL_BIT] = cal_done_i;
      rd_word_o[RDY_BIT] = dll_rdy_i;
    end
  end
endmodule

// File: rtl/wmreg_bank.sv
module wmreg_bank
  import wmreg_pkg::*;
#(
  parameter int P_ADDR_W   = ADDR_W,
  parameter int P_DATA_W   = DATA_W,
  parameter int P_NUM_CTRL = NUM_CTRL
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [P_ADDR_W-1:0]   addr_i,
  input  logic [P_DATA_W-1:0]   wdata_i,
  input  logic                  we_i,
  input  logic                  re_i,
  output logic [P_DATA_W-1:0]   rdata_o,
  input  logic                  cal_done_i,
  input  logic                  dll_rdy_i,
  output logic [FREQ_W-1:0]     freq_sel_o,
  output logic [DRV_W-1:0]      drv_sel_o,
  output logic                  tap_en_o,
  output logic [TAPSEL_W-1:0]   tap_sel_o,
  output logic                  pwr_up_o,
  output logic                  dll_en_o
);
  localparam int P_HALF_W = P_DATA_W / 2;

  logic [P_NUM_CTRL-1:0]               ctrl_sel;
  logic                                stat_sel;
  logic [P_NUM_CTRL-1:0][P_HALF_W-1:0] ctrl_q;
  logic [P_DATA_W-1:0]                 rd_word;

  wmreg_decode #(
    .ADDR_W   (P_ADDR_W),
    .NUM_CTRL (P_NUM_CTRL),
    .STAT_OFS (STAT_OFS)
  ) u_decode (
    .addr_i     (addr_i),
    .ctrl_sel_o (ctrl_sel),
    .stat_sel_o (stat_sel)
  );

  for (genvar i = 0; i < P_NUM_CTRL; i++) begin : g_reg
    wmreg_cell #(.HALF_W(P_HALF_W)) u_cell (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_en_i (we_i && ctrl_sel[i]),
      .wdata_i (wdata_i),
      .q_o     (ctrl_q[i])
    );
  end

  wmreg_rdmux #(
    .DATA_W   (P_DATA_W),
    .HALF_W   (P_HALF_W),
    .NUM_CTRL (P_NUM_CTRL),
    .CAL_BIT  (CAL_BIT),
    .RDY_BIT  (RDY_BIT)
  ) u_rdmux (
    .ctrl_q_i   (ctrl_q),
    .ctrl_sel_i (ctrl_sel),
    .stat_sel_i (stat_sel),
    .cal_done_i (cal_done_i),
    .dll_rdy_i  (dll_rdy_i),
    .rd_word_o  (rd_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= rd_word;
  end

  assign freq_sel_o = ctrl_q[CFG_IDX][FREQ_LSB +: FREQ_W];
  assign tap_en_o   = ctrl_q[CFG_IDX][TAPEN_BIT];
  assign tap_sel_o  = ctrl_q[CFG_IDX][TAPSEL_LSB +: TAPSEL_W];
  assign pwr_up_o   = ctrl_q[PWR_IDX][PWR_BIT];
  assign dll_en_o   = ctrl_q[PWR_IDX][DLLEN_BIT];
  assign drv_sel_o  = ctrl_q[PWR_IDX][DRV_LSB +: DRV_W];
endmodule

// File: rtl/wmreg_bank_chk.sv
module wmreg_bank_chk
  import wmreg_pkg::*;
(
  input logic                clk_i,
  input logic                rst_ni,
  input logic [ADDR_W-1:0]   addr_i,
  input logic [DATA_W-1:0]   wdata_i,
  input logic                we_i,
  input logic                re_i,
  input logic [DATA_W-1:0]   rdata_o,
  input logic                cal_done_i,
  input logic                dll_rdy_i,
  input logic [FREQ_W-1:0]   freq_sel_o,
  input logic [DRV_W-1:0]    drv_sel_o,
  input logic                tap_en_o,
  input logic [TAPSEL_W-1:0] tap_sel_o,
  input logic                pwr_up_o,
  input logic                dll_en_o
);
  localparam logic [ADDR_W-1:0] PWR_ADDR  = ADDR_W'(PWR_IDX * 4);
  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(STAT_OFS);
  localparam logic [DATA_W-1:0] STAT_MASK = (DATA_W'(1) << CAL_BIT) | (DATA_W'(1) << RDY_BIT);

  logic ctrl_hit;
  logic map_hit;
  logic [10:0] outs;

  assign ctrl_hit = (addr_i[1:0] == 2'b00) && (addr_i < ADDR_W'(NUM_CTRL * 4));
  assign map_hit  = ctrl_hit || (addr_i == STAT_ADDR);
  assign outs     = {freq_sel_o, drv_sel_o, tap_en_o, tap_sel_o, pwr_up_o};

  // R1
  mask_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == PWR_ADDR && !wdata_i[HALF_W + PWR_BIT]) |=> $stable(pwr_up_o));

  // R1
  mask_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == PWR_ADDR && wdata_i[HALF_W + DLLEN_BIT]) |=> dll_en_o == $past(wdata_i[DLLEN_BIT]));

  // R3
  upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && ctrl_hit) |=> rdata_o[DATA_W-1:HALF_W] == '0);

  // R3
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rdata_o));

  // R4
  status_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && addr_i == STAT_ADDR) |=> (rdata_o[CAL_BIT] == $past(cal_done_i)) &&
      (rdata_o[RDY_BIT] == $past(dll_rdy_i)) && ((rdata_o & ~STAT_MASK) == '0));

  // R5
  ignored_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !ctrl_hit) |=> $stable(outs) && $stable(dll_en_o));

  // R5
  unmapped_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && !map_hit) |=> rdata_o == '0);
endmodule

bind wmreg_bank wmreg_bank_chk chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .we_i       (we_i),
  .re_i       (re_i),
  .rdata_o    (rdata_o),
  .cal_done_i (cal_done_i),
  .dll_rdy_i  (dll_rdy_i),
  .freq_sel_o (freq_sel_o),
  .drv_sel_o  (drv_sel_o),
  .tap_en_o   (tap_en_o),
  .tap_sel_o  (tap_sel_o),
  .pwr_up_o   (pwr_up_o),
  .dll_en_o   (dll_en_o)
);

// File: tb/wmreg_bank_tb_top.sv
`timescale 1ns/1ps
module wmreg_bank_tb_top;
  localparam time TCK = 20ns;

  typedef struct packed {
    logic        we;
    logic        re;
    logic [5:0]  addr;
    logic [31:0] wdata;
    logic [31:0] exp;
    logic [15:0] tag;
  } vec_t;

  localparam int NV = 29;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 6'h00, 32'hFFFF_A5A5, 32'h0, "R1"},
    '{1'b0, 1'b1, 6'h00, 32'h0, 32'h0000_A5A5, "R3"},
    '{1'b1, 1'b0, 6'h00, 32'h00F0_0000, 32'h0, "R1"},
    '{1'b0, 1'b1, 6'h00, 32'h0, 32'h0000_A505, "R1"},
    '{1'b1, 1'b0, 6'h04, 32'h0000_FFFF, 32'h0, "R1"},
    '{1'b0, 1'b1, 6'h04, 32'h0, 32'h0, "R1"},
    '{1'b1, 1'b0, 6'h04, 32'h8001_8001, 32'h0, "R1"},
    '{1'b0, 1'b1, 6'h04, 32'h0, 32'h0000_8001, "R3"},
    '{1'b1, 1'b0, 6'h08, 32'hFFFF_1111, 32'h0, "R2"},
    '{1'b1, 1'b0, 6'h0C, 32'hFFFF_2222, 32'h0, "R2"},
    '{1'b1, 1'b0, 6'h10, 32'hFFFF_3333, 32'h0, "R2"},
    '{1'b1, 1'b0, 6'h14, 32'hFFFF_BEEF, 32'h0, "R2"},
    '{1'b1, 1'b0, 6'h18, 32'hFFFF_1234, 32'h0, "R2"},
    '{1'b0, 1'b1, 6'h08, 32'h0, 32'h0000_1111, "R2"},
    '{1'b0, 1'b1, 6'h0C, 32'h0, 32'h0000_2222, "R2"},
    '{1'b0, 1'b1, 6'h10, 32'h0, 32'h0000_3333, "R2"},
    '{1'b0, 1'b1, 6'h14, 32'h0, 32'h0000_BEEF, "R2"},
    '{1'b0, 1'b1, 6'h18, 32'h0, 32'h0000_1234, "R2"},
    '{1'b1, 1'b0, 6'h20, 32'hFFFF_FFFF, 32'h0, "R5"},
    '{1'b1, 1'b0, 6'h1C, 32'hFFFF_FFFF, 32'h0, "R5"},
    '{1'b1, 1'b0, 6'h01, 32'hFFFF_FFFF, 32'h0, "R5"},
    '{1'b0, 1'b1, 6'h1C, 32'h0, 32'h0, "R5"},
    '{1'b0, 1'b1, 6'h02, 32'h0, 32'h0, "R5"},
    '{1'b0, 1'b1, 6'h3C, 32'h0, 32'h0, "R5"},
    '{1'b0, 1'b1, 6'h00, 32'h0, 32'h0000_A505, "R5"},
    '{1'b0, 1'b1, 6'h18, 32'h0, 32'h0000_1234, "R5"},
    '{1'b0, 1'b1, 6'h20, 32'h0, 32'h0000_0040, "R4"},
    '{1'b1, 1'b1, 6'h04, 32'hFFFF_0000, 32'h0000_8001, "R3"},
    '{1'b0, 1'b1, 6'h04, 32'h0, 32'h0, "R1"}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [5:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic        we_i = 1'b0;
  logic        re_i = 1'b0;
  logic        cal_done_i = 1'b0;
  logic        dll_rdy_i = 1'b0;
  logic [31:0] rdata_o;
  logic [1:0]  freq_sel_o;
  logic [2:0]  drv_sel_o;
  logic        tap_en_o;
  logic [3:0]  tap_sel_o;
  logic        pwr_up_o;
  logic        dll_en_o;

  int n_chk = 0;
  int n_bad = 0;

  always #(TCK/2) clk_i = ~clk_i;

  wmreg_bank dut_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .we_i       (we_i),
    .re_i       (re_i),
    .rdata_o    (rdata_o),
    .cal_done_i (cal_done_i),
    .dll_rdy_i  (dll_rdy_i),
    .freq_sel_o (freq_sel_o),
    .drv_sel_o  (drv_sel_o),
    .tap_en_o   (tap_en_o),
    .tap_sel_o  (tap_sel_o),
    .pwr_up_o   (pwr_up_o),
    .dll_en_o   (dll_en_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // one bus cycle: drive at falling edge, return one falling edge later
  task automatic bus_op(input logic we, input logic re, input logic [5:0] a, input logic [31:0] d);
    @(negedge clk_i);
    we_i = we; re_i = re; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    we_i = 1'b0; re_i = 1'b0; addr_i = '0; wdata_i = '0;
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(TCK * 100000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    #1;
    // R6 reset state
    chk("R6", rdata_o, 32'h0);
    chk("R6", {22'h0, freq_sel_o, drv_sel_o, tap_en_o, tap_sel_o}, 32'h0);
    chk("R6", {30'h0, pwr_up_o, dll_en_o}, 32'h0);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;

    cal_done_i = 1'b1;
    dll_rdy_i  = 1'b0;
    for (int i = 0; i < NV; i++) begin
      bus_op(VECS[i].we, VECS[i].re, VECS[i].addr, VECS[i].wdata);
      if (VECS[i].re) chk(string'(VECS[i].tag), rdata_o, VECS[i].exp);
    end

    // R3 hold between reads
    @(negedge clk_i);
    chk("R3", rdata_o, 32'h0);

    // R4 other status combinations
    cal_done_i = 1'b0; dll_rdy_i = 1'b1;
    bus_op(1'b0, 1'b1, 6'h20, 32'h0);
    chk("R4", rdata_o, 32'h0000_0020);
    cal_done_i = 1'b1;
    bus_op(1'b0, 1'b1, 6'h20, 32'h0);
    chk("R4", rdata_o, 32'h0000_0060);

    // R7 power and DLL enable; register 0x18 holds 0x1234 here
    bus_op(1'b1, 1'b0, 6'h18, 32'h0003_0001);
    chk("R7", {30'h0, pwr_up_o, dll_en_o}, 32'h2);
    bus_op(1'b1, 1'b0, 6'h18, 32'h0002_0002);
    chk("R7", {30'h0, pwr_up_o, dll_en_o}, 32'h3);

    // R8 drive field: 0x1234 has bits 6:4 = 3 (100 ohm); set 4 (40 ohm)
    chk("R8", {29'h0, drv_sel_o}, 32'h3);
    bus_op(1'b1, 1'b0, 6'h18, 32'h0070_0040);
    chk("R8", {29'h0, drv_sel_o}, 32'h4);
    chk("R8", {30'h0, pwr_up_o, dll_en_o}, 32'h3);

    // R9 and R10: frequency 2 (100 MHz), tap enable, tap select 4
    bus_op(1'b1, 1'b0, 6'h00, 32'h3F80_2A00);
    chk("R9", {30'h0, freq_sel_o}, 32'h2);
    chk("R10", {27'h0, tap_en_o, tap_sel_o}, 32'h14);
    bus_op(1'b1, 1'b0, 6'h00, 32'h3000_3000);
    chk("R9", {30'h0, freq_sel_o}, 32'h3);
    chk("R10", {27'h0, tap_en_o, tap_sel_o}, 32'h14);

    // R6 reset in mid-run
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk("R6", {30'h0, pwr_up_o, dll_en_o}, 32'h0);
    chk("R6", rdata_o, 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    bus_op(1'b0, 1'b1, 6'h00, 32'h0);
    chk("R6", rdata_o, 32'h0);

    finish_run();
  end
endmodule